// File: doc/BRIEF.md
# Perforated Huge-Page Walk Finisher

This block completes the last step of a page walk for a 2MB mapping that may contain separately mapped 4KB holes. The upper walk levels hand it the 2MB-level entry, the physical address where that entry lives, and the virtual address being translated. It then decides, with at most two memory reads, whether the target falls in a hole. If it does, it returns the translation of the 4KB page. If it does not, it returns the translation of the surrounding 2MB page. A page-size flag comes with every result so the TLB fill logic knows which kind of entry to build.

The decision has two stages. Eight spare bits of the 2MB entry act as a coarse filter. Each bit covers one eighth of the huge page, which is 64 consecutive 4KB slots. When the filter bit for the target's eighth is clear, no memory is touched. When it is set, the walker reads one 64-byte line from a global bit-vector region. That line holds one hole bit for each of the 512 physical 4KB frames behind the huge page. A set bit sends the walker to a shadow entry that sits 4KB above the 2MB entry. The shadow entry uses the ordinary 4KB leaf format. The fetched 64-byte vector is also returned, so the L2 TLB can keep it.

Three interfaces carry data: walk requests in, results out, and memory requests and responses. Each of them uses valid/ready handshakes. A transfer happens on a rising clock edge where both valid and ready are high. A sender that raises valid keeps valid and its payload unchanged until that transfer. The walker holds one walk at a time.

Top module: `hugehole_walker`

## Requirements
- R1: While reset is applied and after it is released, `walk_ready` is 1, and `busy`, `res_valid`, `mreq_valid` and `mrsp_ready` are 0.
- R2: The coarse bit used is entry bit 52+k, where k is vaddr[20:18]. When that bit is 0, the walk issues no memory request. It returns a 2MB result.
- R3: When the coarse bit is 1, the walk reads the vector line at exactly one address. That address is `VEC_BASE` + (entry[39:21] × 64), which is 64-byte aligned. Every memory request address has its low 6 bits at 0.
- R4: The fine bit is bit vaddr[20:12] of the 512-bit response line, counted from bit 0. When that bit is 0, no further request is made and the result is a 2MB result.
- R5: When the fine bit is 1, the second request goes to the line containing (entry address + 4096) with its low 6 bits cleared. The shadow entry is 64-bit word number (entry address + 4096)[5:3] of that line, where word w occupies bits [64w+63:64w].
- R6: A 2MB result has `res_pa` = {entry[39:21], vaddr[20:0]} and `res_attr` = entry[11:0]. A 4KB result has `res_pa` = {shadow[39:12], vaddr[11:0]} and `res_attr` = shadow[11:0].
- R7: `res_is4k` is 1 for a 4KB result and 0 for a 2MB result. A 4KB result always has `res_vec_ok` at 1.
- R8: `res_vec_ok` is 1 exactly when the vector line was fetched. `res_vec` then equals that line. Otherwise `res_vec` is all zeros.
- R9: `busy` rises the cycle after a walk is accepted and stays high until the result transfer. `walk_ready` is 0 whenever `busy` is 1.
- R10: While `res_valid` is 1 and `res_ready` is 0, the result fields do not change. While `mreq_valid` is 1 and `mreq_ready` is 0, `mreq_addr` does not change.
- R11: `mrsp_ready` is 1 only while an accepted memory request awaits its response. It is never 1 while idle, while requesting, or while a result is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| walk_valid | input | 1 | Walk request offered |
| walk_ready | output | 1 | Walker can accept a walk |
| walk_vaddr | input | VA_W (48) | Virtual address to translate |
| walk_pte | input | 64 | Fetched 2MB-level entry |
| walk_pte_addr | input | PA_W (40) | Physical address of that entry |
| busy | output | 1 | A walk is in progress |
| res_valid | output | 1 | Result offered |
| res_ready | input | 1 | Result consumer ready |
| res_pa | output | PA_W (40) | Translated physical address |
| res_is4k | output | 1 | 1: 4KB result, 0: 2MB result |
| res_attr | output | 12 | Attribute bits of the chosen entry |
| res_vec_ok | output | 1 | `res_vec` holds a fetched vector line |
| res_vec | output | 512 | Fetched hole vector |
| mreq_valid | output | 1 | Memory read request offered |
| mreq_ready | input | 1 | Memory accepts the request |
| mreq_addr | output | PA_W (40) | 64-byte aligned line address |
| mrsp_valid | input | 1 | Memory response offered |
| mrsp_ready | output | 1 | Walker accepts the response |
| mrsp_data | input | 512 | Returned line |

## Verification
The bench uses the default parameters: 48-bit virtual addresses, 40-bit physical addresses, eight coarse bits starting at entry bit 52, and a vector region at 0xF0_0000_0000. With these values, every coarse group can be reached, every fine bit position from 0 to 511 can be reached, and all eight shadow word slots in a line can be reached. Directed walks pin the extremes: group 7 with fine bit 511, group 0 with fine bit 0, a coarse filter that is full except at the target, and shadow words 0 and 7. Random walks mix coarse hits, false positives and holes. The memory side has random back-pressure and random response latency. The result side also applies random back-pressure.

// File: rtl/hhw_pkg.sv
package hhw_pkg;

  // Page geometry; the hole vector layout depends on these values.
  localparam int unsigned SMALL_SHIFT = 12;
  localparam int unsigned HUGE_SHIFT  = 21;
  localparam int unsigned SLOT_BITS   = HUGE_SHIFT - SMALL_SHIFT;
  localparam int unsigned SLOTS       = 1 << SLOT_BITS;
  localparam int unsigned ENT_SHIFT   = 3;
  localparam int unsigned ENT_BITS    = 8 << ENT_SHIFT;
  localparam int unsigned LINE_SHIFT  = SLOT_BITS - 3;
  localparam int unsigned ATTR_BITS   = SMALL_SHIFT;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_DECIDE,
    WS_VEC_REQ,
    WS_VEC_WAIT,
    WS_SH_REQ,
    WS_SH_WAIT,
    WS_DONE
  } walk_state_e;

endpackage

// File: rtl/hhw_hole_test.sv
module hhw_hole_test
  import hhw_pkg::*;
#(
  parameter int FILT_W = 8
) (
  input  logic [FILT_W-1:0]    filt,
  input  logic [SLOT_BITS-1:0] slot,
  input  logic [SLOTS-1:0]     line,
  output logic                 coarse_hit,
  output logic                 fine_hit
);

  localparam int CI_W = $clog2(FILT_W);

  logic [CI_W-1:0] group;

  // The top bits of the slot number choose the coarse group.
  assign group      = slot[SLOT_BITS-1 -: CI_W];
  assign coarse_hit = filt[group];
  assign fine_hit   = line[slot];

endmodule

// File: rtl/hhw_addr_gen.sv
module hhw_addr_gen
  import hhw_pkg::*;
#(
  parameter int              PA_W     = 40,
  parameter logic [PA_W-1:0] VEC_BASE = '0
) (
  input  logic [PA_W-HUGE_SHIFT-1:0] frame,
  input  logic [PA_W-ENT_SHIFT-1:0]  ent_idx,
  output logic [PA_W-1:0]            vec_addr,
  output logic [PA_W-1:0]            sh_addr,
  output logic [LINE_SHIFT-ENT_SHIFT-1:0] sh_word
);

  localparam int ENT_W = PA_W - ENT_SHIFT;
  localparam int WI_W  = LINE_SHIFT - ENT_SHIFT;
  localparam int FR_W  = PA_W - HUGE_SHIFT;

  logic [ENT_W-1:0] sh_idx;

  // One vector line per huge frame, packed line after line.
  assign vec_addr = VEC_BASE + PA_W'({frame, {LINE_SHIFT{1'b0}}});

  // Shadow table page sits one small page above the main table page.
  assign sh_idx  = ent_idx + ENT_W'(1 << (SMALL_SHIFT - ENT_SHIFT));
  assign sh_addr = {sh_idx[ENT_W-1:WI_W], {LINE_SHIFT{1'b0}}};
  assign sh_word = sh_idx[WI_W-1:0];

  if (FR_W + LINE_SHIFT > PA_W) begin : g_bad_width
    initial $display("hhw_addr_gen: physical width too small");
  end

endmodule

// File: rtl/hhw_word_sel.sv
module hhw_word_sel
  import hhw_pkg::*;
#(
  parameter int LINE_W = 512,
  parameter int WORD_W = 64
) (
  input  logic [LINE_W-1:0]                 line,
  input  logic [$clog2(LINE_W/WORD_W)-1:0]  idx,
  output logic [WORD_W-1:0]                 word
);

  localparam int WORDS = LINE_W / WORD_W;

  logic [WORD_W-1:0] words [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_slice
    assign words[g] = line[g*WORD_W +: WORD_W];
  end

  assign word = words[idx];

endmodule

// File: rtl/hhw_ctrl.sv
module hhw_ctrl
  import hhw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic walk_valid,
  input  logic res_ready,
  input  logic mreq_ready,
  input  logic mrsp_valid,
  input  logic coarse_hit,
  input  logic fine_hit,
  output logic walk_ready,
  output logic busy,
  output logic res_valid,
  output logic mreq_valid,
  output logic mreq_sel_sh,
  output logic mrsp_ready,
  output logic cap_walk,
  output logic cap_vec,
  output logic cap_sh
);

  walk_state_e st_q, st_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= WS_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      WS_IDLE:     if (walk_valid) st_d = WS_DECIDE;
      WS_DECIDE:   st_d = coarse_hit ? WS_VEC_REQ : WS_DONE;
      WS_VEC_REQ:  if (mreq_ready) st_d = WS_VEC_WAIT;
      WS_VEC_WAIT: if (mrsp_valid) st_d = fine_hit ? WS_SH_REQ : WS_DONE;
      WS_SH_REQ:   if (mreq_ready) st_d = WS_SH_WAIT;
      WS_SH_WAIT:  if (mrsp_valid) st_d = WS_DONE;
      WS_DONE:     if (res_ready) st_d = WS_IDLE;
      default:     st_d = WS_IDLE;
    endcase
  end

  assign walk_ready  = (st_q == WS_IDLE);
  assign busy        = (st_q != WS_IDLE);
  assign res_valid   = (st_q == WS_DONE);
  assign mreq_valid  = (st_q == WS_VEC_REQ) || (st_q == WS_SH_REQ);
  assign mreq_sel_sh = (st_q == WS_SH_REQ);
  assign mrsp_ready  = (st_q == WS_VEC_WAIT) || (st_q == WS_SH_WAIT);
  assign cap_walk    = (st_q == WS_IDLE) && walk_valid;
  assign cap_vec     = (st_q == WS_VEC_WAIT) && mrsp_valid;
  assign cap_sh      = (st_q == WS_SH_WAIT) && mrsp_valid;

endmodule

// File: rtl/hugehole_walker.sv
module hugehole_walker
  import hhw_pkg::*;
#(
  parameter int              VA_W     = 48,
  parameter int              PA_W     = 40,
  parameter int              FILT_LSB = 52,
  parameter int              FILT_W   = 8,
  parameter logic [PA_W-1:0] VEC_BASE = 40'hF0_0000_0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 walk_valid,
  output logic                 walk_ready,
  input  logic [VA_W-1:0]      walk_vaddr,
  input  logic [ENT_BITS-1:0]  walk_pte,
  input  logic [PA_W-1:0]      walk_pte_addr,
  output logic                 busy,
  output logic                 res_valid,
  input  logic                 res_ready,
  output logic [PA_W-1:0]      res_pa,
  output logic                 res_is4k,
  output logic [ATTR_BITS-1:0] res_attr,
  output logic                 res_vec_ok,
  output logic [SLOTS-1:0]     res_vec,
  output logic                 mreq_valid,
  input  logic                 mreq_ready,
  output logic [PA_W-1:0]      mreq_addr,
  input  logic                 mrsp_valid,
  output logic                 mrsp_ready,
  input  logic [SLOTS-1:0]     mrsp_data
);

  localparam int FR_W  = PA_W - HUGE_SHIFT;
  localparam int SF_W  = PA_W - SMALL_SHIFT;
  localparam int ENT_W = PA_W - ENT_SHIFT;
  localparam int WI_W  = LINE_SHIFT - ENT_SHIFT;

  // Captured walk context (only the fields the walk consumes)
  logic [HUGE_SHIFT-1:0] voff_q;
  logic [FR_W-1:0]       frame_q;
  logic [ATTR_BITS-1:0]  attr2m_q;
  logic [FILT_W-1:0]     filt_q;
  logic [ENT_W-1:0]      ent_q;
  // Collected results
  logic [SLOTS-1:0]      line_q;
  logic                  vec_ok_q;
  logic                  is4k_q;
  logic [SF_W-1:0]       sh_frame_q;
  logic [ATTR_BITS-1:0]  sh_attr_q;

  logic coarse_hit, fine_hit;
  logic cap_walk, cap_vec, cap_sh, mreq_sel_sh;
  logic [PA_W-1:0]     vec_addr, sh_addr;
  logic [WI_W-1:0]     sh_word_idx;
  logic [ENT_BITS-1:0] sh_word;
  logic                unused_bits;

  hhw_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .walk_valid (walk_valid),
    .res_ready  (res_ready),
    .mreq_ready (mreq_ready),
    .mrsp_valid (mrsp_valid),
    .coarse_hit (coarse_hit),
    .fine_hit   (fine_hit),
    .walk_ready (walk_ready),
    .busy       (busy),
    .res_valid  (res_valid),
    .mreq_valid (mreq_valid),
    .mreq_sel_sh(mreq_sel_sh),
    .mrsp_ready (mrsp_ready),
    .cap_walk   (cap_walk),
    .cap_vec    (cap_vec),
    .cap_sh     (cap_sh)
  );

  // Fine bit is taken straight off the response so the branch costs no cycle.
  hhw_hole_test #(.FILT_W(FILT_W)) u_hole (
    .filt      (filt_q),
    .slot      (voff_q[HUGE_SHIFT-1:SMALL_SHIFT]),
    .line      (mrsp_data),
    .coarse_hit(coarse_hit),
    .fine_hit  (fine_hit)
  );

  hhw_addr_gen #(.PA_W(PA_W), .VEC_BASE(VEC_BASE)) u_addr (
    .frame   (frame_q),
    .ent_idx (ent_q),
    .vec_addr(vec_addr),
    .sh_addr (sh_addr),
    .sh_word (sh_word_idx)
  );

  hhw_word_sel #(.LINE_W(SLOTS), .WORD_W(ENT_BITS)) u_word (
    .line(mrsp_data),
    .idx (sh_word_idx),
    .word(sh_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      voff_q     <= '0;
      frame_q    <= '0;
      attr2m_q   <= '0;
      filt_q     <= '0;
      ent_q      <= '0;
      line_q     <= '0;
      vec_ok_q   <= 1'b0;
      is4k_q     <= 1'b0;
      sh_frame_q <= '0;
      sh_attr_q  <= '0;
    end else if (cap_walk) begin
      voff_q     <= walk_vaddr[HUGE_SHIFT-1:0];
      frame_q    <= walk_pte[PA_W-1:HUGE_SHIFT];
      attr2m_q   <= walk_pte[ATTR_BITS-1:0];
      filt_q     <= walk_pte[FILT_LSB +: FILT_W];
      ent_q      <= walk_pte_addr[PA_W-1:ENT_SHIFT];
      line_q     <= '0;
      vec_ok_q   <= 1'b0;
      is4k_q     <= 1'b0;
      sh_frame_q <= '0;
      sh_attr_q  <= '0;
    end else if (cap_vec) begin
      line_q   <= mrsp_data;
      vec_ok_q <= 1'b1;
    end else if (cap_sh) begin
      is4k_q     <= 1'b1;
      sh_frame_q <= sh_word[PA_W-1:SMALL_SHIFT];
      sh_attr_q  <= sh_word[ATTR_BITS-1:0];
    end
  end

  assign mreq_addr  = mreq_sel_sh ? sh_addr : vec_addr;
  assign res_pa     = is4k_q ? {sh_frame_q, voff_q[SMALL_SHIFT-1:0]}
                             : {frame_q, voff_q};
  assign res_attr   = is4k_q ? sh_attr_q : attr2m_q;
  assign res_is4k   = is4k_q;
  assign res_vec_ok = vec_ok_q;
  assign res_vec    = line_q;

  assign unused_bits = ^{walk_vaddr, walk_pte, walk_pte_addr[ENT_SHIFT-1:0], sh_word};

endmodule

// File: rtl/hhw_walk_chk.sv
module hhw_walk_chk
  import hhw_pkg::*;
#(
  parameter int PA_W = 40
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 walk_valid,
  input logic                 walk_ready,
  input logic                 busy,
  input logic                 res_valid,
  input logic                 res_ready,
  input logic [PA_W-1:0]      res_pa,
  input logic                 res_is4k,
  input logic [ATTR_BITS-1:0] res_attr,
  input logic                 res_vec_ok,
  input logic                 mreq_valid,
  input logic                 mreq_ready,
  input logic [PA_W-1:0]      mreq_addr,
  input logic                 mrsp_ready
);

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_valid && walk_ready) |=> busy);

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(res_valid && res_ready)) |=> busy);

  // R9
  single_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !walk_ready);

  // R10
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_pa) && $stable(res_is4k)
                                   && $stable(res_attr) && $stable(res_vec_ok)));

  // R10
  mreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_addr)));

  // R3
  line_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid |-> (mreq_addr[LINE_SHIFT-1:0] == '0));

  // R11
  rsp_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mrsp_ready |-> (busy && !mreq_valid && !res_valid));

  // R7
  small_needs_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_is4k) |-> res_vec_ok);

endmodule

bind hugehole_walker hhw_walk_chk #(.PA_W(PA_W)) u_walk_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .walk_valid(walk_valid),
  .walk_ready(walk_ready),
  .busy      (busy),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_pa    (res_pa),
  .res_is4k  (res_is4k),
  .res_attr  (res_attr),
  .res_vec_ok(res_vec_ok),
  .mreq_valid(mreq_valid),
  .mreq_ready(mreq_ready),
  .mreq_addr (mreq_addr),
  .mrsp_ready(mrsp_ready)
);

// File: tb/test_hugehole_walker.sv
`timescale 1ns/1ps
module test_hugehole_walker;

  localparam int VA_W = 48;
  localparam int PA_W = 40;
  localparam logic [PA_W-1:0] VEC_BASE = 40'hF0_0000_0000;

  logic clk = 1'b0;
  logic rst_n;
  logic walk_valid, walk_ready;
  logic [VA_W-1:0] walk_vaddr;
  logic [63:0] walk_pte;
  logic [PA_W-1:0] walk_pte_addr;
  logic busy, res_valid, res_ready, res_is4k, res_vec_ok;
  logic [PA_W-1:0] res_pa;
  logic [11:0] res_attr;
  logic [511:0] res_vec;
  logic mreq_valid, mreq_ready, mrsp_valid, mrsp_ready;
  logic [PA_W-1:0] mreq_addr;
  logic [511:0] mrsp_data;

  always #10 clk = ~clk;

  hugehole_walker #(.VA_W(VA_W), .PA_W(PA_W), .VEC_BASE(VEC_BASE)) i_hugehole_walker (
    .clk(clk), .rst_n(rst_n),
    .walk_valid(walk_valid), .walk_ready(walk_ready), .walk_vaddr(walk_vaddr),
    .walk_pte(walk_pte), .walk_pte_addr(walk_pte_addr), .busy(busy),
    .res_valid(res_valid), .res_ready(res_ready), .res_pa(res_pa),
    .res_is4k(res_is4k), .res_attr(res_attr), .res_vec_ok(res_vec_ok), .res_vec(res_vec),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_addr(mreq_addr),
    .mrsp_valid(mrsp_valid), .mrsp_ready(mrsp_ready), .mrsp_data(mrsp_data)
  );

  int checks = 0;
  int errors = 0;

  // Memory model contents for the current walk
  logic [511:0]    m_vec_line;
  logic [63:0]     m_sh_entry;
  logic [PA_W-1:0] m_vec_addr, m_sh_line;
  logic [2:0]      m_sh_word;
  int              m_nreq;
  logic [PA_W-1:0] m_addr [2];

  task automatic chk(input string req, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [511:0] rnd_line();
    logic [511:0] l;
    for (int i = 0; i < 16; i++) l[i*32 +: 32] = $urandom();
    return l;
  endfunction

  function automatic logic [511:0] mem_lookup(input logic [PA_W-1:0] a);
    logic [511:0] l;
    if (a == m_vec_addr) return m_vec_line;
    if (a == m_sh_line) begin
      l = rnd_line();
      l[m_sh_word*64 +: 64] = m_sh_entry;
      return l;
    end
    return '0;
  endfunction

  // Memory responder: random accept delay and random response latency
  initial begin : mem_model
    logic pend, waited;
    int dly;
    logic [511:0] pdata;
    logic [PA_W-1:0] wait_addr;
    pend = 0; waited = 0; dly = 0; pdata = '0; wait_addr = '0;
    mreq_ready = 0; mrsp_valid = 0; mrsp_data = '0;
    forever begin
      @(negedge clk);
      if (mrsp_valid) begin
        mrsp_valid = 0;
        mrsp_data  = rnd_line();
      end else if (pend) begin
        if (dly > 0) dly--;
        else if (mrsp_ready) begin
          mrsp_valid = 1; mrsp_data = pdata; pend = 0;
        end
      end
      if (mreq_ready) begin
        mreq_ready = 0; waited = 0;
      end else if (mreq_valid) begin
        if (waited) chk("R10", "request address held", mreq_addr, wait_addr);
        if (!pend && !mrsp_valid && ($urandom() % 3 != 0)) begin
          mreq_ready = 1; waited = 0;
          if (m_nreq < 2) m_addr[m_nreq] = mreq_addr;
          m_nreq++;
          pend  = 1;
          dly   = $urandom() % 4;
          pdata = mem_lookup(mreq_addr);
        end else begin
          waited = 1; wait_addr = mreq_addr;
        end
      end
    end
  end

  task automatic run_walk(input logic [VA_W-1:0] va, input logic [63:0] pte,
                          input logic [PA_W-1:0] paddr, input logic [511:0] vline,
                          input logic [63:0] shent);
    logic coarse, fine, done, stalled;
    logic [PA_W-1:0] sh_sum, exp_pa, rec_pa;
    logic [11:0] exp_attr;
    logic [PA_W-1:0] got_pa;
    logic got_4k, got_vok, rec_4k;
    logic [11:0] got_attr;
    logic [511:0] got_vec;
    int exp_n;
    string req_n;
    coarse = pte[52 + va[20:18]];
    fine   = vline[va[20:12]];
    sh_sum = paddr + 40'd4096;
    m_vec_line = vline;
    m_sh_entry = shent;
    m_vec_addr = VEC_BASE + {15'd0, pte[39:21], 6'd0};
    m_sh_line  = {sh_sum[PA_W-1:6], 6'd0};
    m_sh_word  = sh_sum[5:3];
    m_nreq     = 0;
    m_addr[0]  = '0;
    m_addr[1]  = '0;

    @(negedge clk);
    chk("R9", "ready when idle", walk_ready, 1);
    walk_valid = 1; walk_vaddr = va; walk_pte = pte; walk_pte_addr = paddr;
    @(negedge clk);
    walk_valid = 0;
    walk_vaddr = {$urandom(), $urandom()};
    walk_pte = {$urandom(), $urandom()};
    chk("R9", "busy after accept", busy, 1);
    chk("R9", "not ready while busy", walk_ready, 0);

    done = 0; stalled = 0; rec_pa = '0; rec_4k = 0;
    got_pa = '0; got_4k = 0; got_vok = 0; got_attr = '0; got_vec = '0;
    while (!done) begin
      @(negedge clk);
      if (res_valid) begin
        if (stalled) begin
          chk("R10", "result address held", res_pa, rec_pa);
          chk("R10", "size flag held", res_is4k, rec_4k);
        end
        if ($urandom() % 2 == 1) begin
          res_ready = 1;
          got_pa = res_pa; got_4k = res_is4k; got_attr = res_attr;
          got_vok = res_vec_ok; got_vec = res_vec;
          chk("R11", "no response accept while offering", mrsp_ready, 0);
          done = 1;
        end else begin
          res_ready = 0; stalled = 1; rec_pa = res_pa; rec_4k = res_is4k;
        end
      end else begin
        res_ready = $urandom() % 2;
      end
    end
    @(negedge clk);
    res_ready = 0;
    chk("R9", "idle after result", busy, 0);
    chk("R9", "result dropped", res_valid, 0);

    if (!coarse) begin exp_n = 0; req_n = "R2"; end
    else if (!fine) begin exp_n = 1; req_n = "R4"; end
    else begin exp_n = 2; req_n = "R5"; end
    if (exp_n == 2) begin
      exp_pa = {shent[39:12], va[11:0]}; exp_attr = shent[11:0];
    end else begin
      exp_pa = {pte[39:21], va[20:0]}; exp_attr = pte[11:0];
    end
    chk(req_n, "memory request count", m_nreq, exp_n);
    if (exp_n >= 1) chk("R3", "vector line address", m_addr[0], m_vec_addr);
    if (exp_n == 2) chk("R5", "shadow line address", m_addr[1], m_sh_line);
    chk("R7", "page size flag", got_4k, (exp_n == 2));
    chk("R6", "translated address", got_pa, exp_pa);
    chk("R6", "attributes", got_attr, exp_attr);
    chk("R8", "vector valid flag", got_vok, (exp_n >= 1));
    chk("R8", "vector contents", got_vec, (exp_n >= 1) ? vline : 512'd0);
  endtask

  function automatic logic [63:0] mk_pte(input logic [7:0] filt);
    logic [63:0] p;
    p = {$urandom(), $urandom()};
    p[59:52] = filt;
    return p;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [511:0] l;
    void'($urandom(32'h1f2e3d4c));
    rst_n = 0; walk_valid = 0; walk_vaddr = '0; walk_pte = '0; walk_pte_addr = '0;
    res_ready = 0;
    repeat (3) @(negedge clk);
    chk("R1", "ready in reset", walk_ready, 1);
    chk("R1", "busy in reset", busy, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "ready after reset", walk_ready, 1);
    chk("R1", "busy after reset", busy, 0);
    chk("R1", "no result after reset", res_valid, 0);
    chk("R1", "no request after reset", mreq_valid, 0);
    chk("R11", "no response accept when idle", mrsp_ready, 0);

    // R2: coarse filter empty, no memory traffic
    run_walk(48'h1234_5678_9ABC, mk_pte(8'h00), 40'h00_0100_0008, rnd_line(),
             {$urandom(), $urandom()});
    // R4 R5: group 7 (bit 59), fine bit 511, shadow word 7
    l = '0; l[511] = 1'b1;
    run_walk(48'h0000_001F_F123, mk_pte(8'h80), 40'h00_1234_5FF8, l,
             {$urandom(), $urandom()});
    // R4: group 0, fine bit 0 clear while all others set (false positive)
    l = '1; l[0] = 1'b0;
    run_walk(48'h0000_0020_0ABC, mk_pte(8'h01), 40'h00_0000_2000, l,
             {$urandom(), $urandom()});
    // R2: every coarse bit set except the target group 3
    run_walk(48'h0000_000C_4321, mk_pte(8'hF7), 40'h00_0555_0010, '1,
             {$urandom(), $urandom()});
    // R5: hole at slot 69, shadow word 0
    l = '0; l[69] = 1'b1;
    run_walk(48'h0000_0004_5678, mk_pte(8'h02), 40'h00_0ABC_D000, l,
             {$urandom(), $urandom()});

    for (int i = 0; i < 60; i++) begin
      logic [VA_W-1:0] va;
      logic [PA_W-1:0] pa;
      va = {$urandom(), $urandom()};
      pa = {4'h0, $urandom(), 4'h0};
      pa[2:0] = 3'b000;
      run_walk(va, mk_pte(8'($urandom())), pa, rnd_line(), {$urandom(), $urandom()});
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule